// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a memory device. A four-wire port carries the test traffic: a test clock, a mode-select line, serial data in and serial data out. A sixteen-state controller walks the standard test-port graph, one step on each rising test-clock edge, under the mode-select line. A three-bit instruction decides which data register sits between serial-in and serial-out. There are three data registers: a one-bit bypass stage, a 32-bit identification word and a boundary chain of parameterised length. The pin side of the boundary chain is exposed as plain parallel ports, so a pad ring can be wired to it. An active-low asynchronous reset gives the port a known state at power-up.

Inputs are sampled on the rising test-clock edge. Serial-out is retimed to the falling edge and is driven only while a shift state is active. At all other times it floats, and a separate enable pin says whether it is driven. After any reset the identification word is the selected scan path.

The serial interface is a bit-level clocked protocol, so the block has no valid/ready handshake and applies no back-pressure. The test clock itself paces every bit.

Top module: `tap_port`

## Requirements
- R1: While `trst_n` is low, and on the first clock after it rises, `tdo_oe` is 0, `bnd_out` is all zeros, `bnd_drive` is 0 and the active instruction is the identification code 3'b001.
- R2: The controller follows the standard 16-state test-port graph on `tms` at each rising `tck`. Pause-DR and Exit2-DR resume shifting where it stopped.
- R3: Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any of the 16 states, and that state reloads instruction 3'b001.
- R4: Capture-IR loads 3'b001 into the instruction shift stage. The stage shifts toward `tdo` from bit 0, and `tdi` enters at bit 2. A shifted code takes effect only on the rising edge that leaves Update-IR.
- R5: Instruction decode: 3'b000 and 3'b100 select the boundary chain, 3'b001 selects the identification word, and 3'b111 and every other code select the bypass stage. `bnd_drive` is 1 exactly while 3'b000 is active.
- R6: The identification register is 32 bits wide and captures `ID_VALUE` (bit 0 set) in Capture-DR. It shifts with `tdi` into bit 31 and bit 0 toward `tdo`.
- R7: The bypass stage captures 0 in Capture-DR and delays the data by exactly one shift.
- R8: The boundary chain captures `bnd_in` in Capture-DR and has a length of `BSR_LEN` shifts. `tdi` enters at bit `BSR_LEN-1`.
- R9: `bnd_out` takes the chain contents only on the rising edge that leaves Update-DR, while code 3'b000 or 3'b100 is active. Otherwise it holds its value.
- R10: `tdo_oe` is 1 only while the controller is in Shift-DR or Shift-IR. It and `tdo` change on the falling `tck` edge, and `tdo` is high-impedance when not enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low power-on reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data into the selected register |
| tdo | output | 1 | Serial data out, high-impedance outside shift states |
| tdo_oe | output | 1 | High while `tdo` is driven |
| bnd_in | input | BSR_LEN | Pin values captured by the boundary chain |
| bnd_out | output | BSR_LEN | Boundary update latch toward the pads |
| bnd_drive | output | 1 | High while the external-test instruction is active |

## Verification
The first bit of a captured register appears on `tdo` at the falling edge that follows the rising edge entering Shift. Each further bit appears half a period after the rising edge that shifted it. The bench drives `tms` and `tdi` half a nanosecond after a falling edge and samples every output at that same point, so each reading reflects exactly the rising edge and falling edge just passed. An instruction change shows on `bnd_drive` one rising edge after Update-IR is entered, and `bnd_out` changes on the edge that leaves Update-DR. The bench reads both just before and just after those edges to confirm the exact cycle. For each of the eight instruction codes, the expected scan stream is computed as the capture value followed by the serial input delayed by the selected register's length.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;
  localparam int IR_W = 3;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BSR} dr_sel_e;

  function automatic dr_sel_e op_to_sel(input logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPLE: return SEL_BSR;
      OP_IDCODE:            return SEL_ID;
      default:              return SEL_BYP;
    endcase
  endfunction
endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e nxt;

  always_comb begin
    case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= nxt;
  end

  p_tlr_hold_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR && tms) |=> state == ST_TLR);
  p_sel_ir_escape_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_SEL_IR && tms) |=> state == ST_TLR);
  p_capture_to_shift_r2: assert property (@(posedge tck) disable iff (!trst_n)
    ((state == ST_CAP_DR || state == ST_EX2_DR) && !tms) |=> state == ST_SH_DR);
  p_update_to_idle_r2: assert property (@(posedge tck) disable iff (!trst_n)
    ((state == ST_UPD_DR || state == ST_UPD_IR) && !tms) |=> state == ST_RTI);
endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
  import tap_pkg::*;
(
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tdi,
  input  tap_state_e       state,
  output logic             ir_lsb,
  output logic [IR_W-1:0]  ir_active
);
  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr     <= IR_CAPTURE;
      ir_active <= OP_IDCODE;
    end else begin
      case (state)
        ST_CAP_IR: ir_sr <= IR_CAPTURE;
        ST_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        default:   ir_sr <= ir_sr;
      endcase
      if (state == ST_TLR)         ir_active <= OP_IDCODE;
      else if (state == ST_UPD_IR) ir_active <= ir_sr;
    end
  end

  assign ir_lsb = ir_sr[0];

  p_capture_ir_r4: assert property (@(posedge tck) disable iff (!trst_n)
    state == ST_CAP_IR |=> ir_sr == IR_CAPTURE);
  p_ir_hold_r4: assert property (@(posedge tck) disable iff (!trst_n)
    (state != ST_UPD_IR && state != ST_TLR) |=> $stable(ir_active));
  p_tlr_idcode_r3: assert property (@(posedge tck) disable iff (!trst_n)
    state == ST_TLR |=> ir_active == OP_IDCODE);
endmodule

// File: rtl/tap_bsr.sv
`timescale 1ns/1ps
module tap_bsr #(
  parameter int BSR_LEN = 16
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tdi,
  input  logic               cap_en,
  input  logic               sh_en,
  input  logic               upd_en,
  input  logic [BSR_LEN-1:0] bnd_in,
  output logic [BSR_LEN-1:0] bnd_out,
  output logic               bsr_lsb
);
  logic [BSR_LEN-1:0] chain;

  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    logic sin;
    logic cell_sr;
    logic cell_q;
    if (i == BSR_LEN - 1) begin : g_head
      assign sin = tdi;
    end else begin : g_body
      assign sin = chain[i+1];
    end
    always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
        cell_sr <= 1'b0;
        cell_q  <= 1'b0;
      end else begin
        if (cap_en)     cell_sr <= bnd_in[i];
        else if (sh_en) cell_sr <= sin;
        if (upd_en)     cell_q  <= cell_sr;
      end
    end
    assign chain[i]   = cell_sr;
    assign bnd_out[i] = cell_q;
  end

  assign bsr_lsb = chain[0];

  p_bsr_hold_r9: assert property (@(posedge tck) disable iff (!trst_n)
    !upd_en |=> $stable(bnd_out));
  p_bsr_cap_r8: assert property (@(posedge tck) disable iff (!trst_n)
    cap_en |=> chain == $past(bnd_in));
endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
  import tap_pkg::*;
#(
  parameter int              BSR_LEN  = 16,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1A2B_C0DF
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tdi,
  input  tap_state_e         state,
  input  logic [IR_W-1:0]    ir_active,
  input  logic [BSR_LEN-1:0] bnd_in,
  output logic [BSR_LEN-1:0] bnd_out,
  output logic               dr_lsb
);
  dr_sel_e         sel;
  logic            cap, sh, upd;
  logic            byp_q;
  logic [ID_W-1:0] id_sr;
  logic            bsr_lsb;

  assign sel = op_to_sel(ir_active);
  assign cap = (state == ST_CAP_DR);
  assign sh  = (state == ST_SH_DR);
  assign upd = (state == ST_UPD_DR);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
      id_sr <= ID_VALUE;
    end else begin
      if (sel == SEL_BYP) begin
        if (cap)     byp_q <= 1'b0;
        else if (sh) byp_q <= tdi;
      end
      if (sel == SEL_ID) begin
        if (cap)     id_sr <= ID_VALUE;
        else if (sh) id_sr <= {tdi, id_sr[ID_W-1:1]};
      end
    end
  end

  tap_bsr #(.BSR_LEN(BSR_LEN)) u_bsr (
    .tck     (tck),
    .trst_n  (trst_n),
    .tdi     (tdi),
    .cap_en  (cap && sel == SEL_BSR),
    .sh_en   (sh  && sel == SEL_BSR),
    .upd_en  (upd && sel == SEL_BSR),
    .bnd_in  (bnd_in),
    .bnd_out (bnd_out),
    .bsr_lsb (bsr_lsb)
  );

  always_comb begin
    case (sel)
      SEL_ID:  dr_lsb = id_sr[0];
      SEL_BSR: dr_lsb = bsr_lsb;
      default: dr_lsb = byp_q;
    endcase
  end

  p_bypass_cap_r7: assert property (@(posedge tck) disable iff (!trst_n)
    (cap && sel == SEL_BYP) |=> byp_q == 1'b0);
  p_id_cap_r6: assert property (@(posedge tck) disable iff (!trst_n)
    (cap && sel == SEL_ID) |=> id_sr == ID_VALUE);
endmodule

// File: rtl/tap_port.sv
`timescale 1ns/1ps
module tap_port
  import tap_pkg::*;
#(
  parameter int              BSR_LEN  = 16,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1A2B_C0DF
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [BSR_LEN-1:0] bnd_in,
  output logic [BSR_LEN-1:0] bnd_out,
  output logic               bnd_drive
);
  tap_state_e      state;
  logic [IR_W-1:0] ir_active;
  logic            ir_lsb, dr_lsb;
  logic            tdo_q, oe_q;

  tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
  );

  tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
    .ir_lsb(ir_lsb), .ir_active(ir_active)
  );

  tap_dr #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
    .ir_active(ir_active), .bnd_in(bnd_in), .bnd_out(bnd_out),
    .dr_lsb(dr_lsb)
  );

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= (state == ST_SH_DR) || (state == ST_SH_IR);
      tdo_q <= (state == ST_SH_IR) ? ir_lsb : dr_lsb;
    end
  end

  assign tdo       = oe_q ? tdo_q : 1'bz;
  assign tdo_oe    = oe_q;
  assign bnd_drive = (ir_active == OP_EXTEST);

  p_oe_shift_r10: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == (state == ST_SH_DR || state == ST_SH_IR));
endmodule

// File: tb/sim_tap_port.sv
`timescale 1ns/1ps
module sim_tap_port;
  localparam int          N   = 8;
  localparam logic [31:0] IDV = 32'hC35A_9E61;

  logic         tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b1;
  logic [N-1:0] bnd_in = '0;
  wire          tdo, tdo_oe, bnd_drive;
  wire  [N-1:0] bnd_out;
  int           n_cmp = 0, n_bad = 0;

  tap_port #(.BSR_LEN(N), .ID_VALUE(IDV)) u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .tdo_oe(tdo_oe), .bnd_in(bnd_in), .bnd_out(bnd_out), .bnd_drive(bnd_drive)
  );

  always #2 tck = ~tck;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #0.5;
  endtask

  // from Run-Test/Idle back to Run-Test/Idle
  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      tick(i == 2, code[i]);
    end
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic [N-1:0] held;
    dout = '0; held = bnd_out;
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    chk("R10 oe in Shift-DR", 64'(tdo_oe), 64'd1);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tick(i == n - 1, din[i]);
    end
    chk("R10 oe off in Exit1-DR", 64'(tdo_oe), 64'd0);
    chk("R9 bnd_out held before Update-DR", 64'(bnd_out), 64'(held));
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
  endtask

  function automatic logic [5:0] path_bits(input int s);
    case (s)
      1: return 6'b000001;  2: return 6'b000001;  3: return 6'b000001;
      4: return 6'b000101;  5: return 6'b000101;  6: return 6'b010101;
      7: return 6'b001101;  8: return 6'b000011;  9: return 6'b000011;
      10: return 6'b000011; 11: return 6'b001011; 12: return 6'b001011;
      13: return 6'b101011; 14: return 6'b011011; 15: return 6'b000111;
      default: return 6'b000000;
    endcase
  endfunction

  function automatic int path_len(input int s);
    case (s)
      0: return 0;  1: return 1;  2: return 2;  3: return 3;
      4: return 3;  5: return 4;  6: return 5;  7: return 4;
      8: return 2;  9: return 3;  10: return 4; 11: return 4;
      12: return 5; 13: return 6; 14: return 5; default: return 3;
    endcase
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [2:0]   cap;
    logic [63:0]  d, din, expv;
    logic [N-1:0] exp_bnd;
    int           len;
    logic [63:0]  cval;
    exp_bnd = '0;

    #9;
    chk("R1 oe low in reset", 64'(tdo_oe), 64'd0);
    chk("R1 bnd_out cleared", 64'(bnd_out), 64'd0);
    chk("R1 bnd_drive low", 64'(bnd_drive), 64'd0);
    @(negedge tck); #0.5; trst_n = 1'b1;
    tick(1'b1, 1'b0);
    chk("R1 oe low after reset", 64'(tdo_oe), 64'd0);
    tick(1'b0, 1'b0);
    scan_dr(32, 64'd0, d);
    chk("R1 R6 default path is ID", d, 64'(IDV));

    // R2: pause in the middle of a DR shift
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    chk("R2 first ID bit", 64'(tdo), 64'(IDV[0]));
    tick(1'b1, 1'b1); tick(1'b0, 1'b0);
    chk("R10 oe off in Pause-DR", 64'(tdo_oe), 64'd0);
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
    chk("R2 resume after pause", 64'(tdo), 64'(IDV[1]));
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0);

    // R5 R6 R7 R8 R9: every instruction code
    for (int c = 0; c < 8; c++) begin
      bnd_in = N'(8'hA5 ^ 8'(c * 31));
      load_ir(3'(c), cap);
      chk("R4 Capture-IR pattern", 64'(cap), 64'd1);
      chk("R5 bnd_drive per code", 64'(bnd_drive), 64'(c == 0));
      din = 64'h9C3A_5E71_B2D4 ^ (64'(c) * 64'h0101_0101_0101);
      if (c == 0 || c == 4) begin len = N;  cval = 64'(bnd_in); end
      else if (c == 1)      begin len = 32; cval = 64'(IDV);    end
      else                  begin len = 1;  cval = 64'd0;       end
      expv = '0;
      for (int i = 0; i < 48; i++) expv[i] = (i < len) ? cval[i] : din[i - len];
      scan_dr(48, din, d);
      chk("R5 R6 R7 R8 scan stream per code", d, expv);
      if (c == 0 || c == 4) exp_bnd = din[48-N +: N];
      chk("R9 bnd_out after Update-DR", 64'(bnd_out), 64'(exp_bnd));
    end

    // R4: new code applies only after Update-IR
    load_ir(3'b000, cap);
    chk("R4 EXTEST active", 64'(bnd_drive), 64'd1);
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    tick(1'b0, 1'b1); tick(1'b0, 1'b0); tick(1'b1, 1'b0);
    chk("R4 unchanged in Exit1-IR", 64'(bnd_drive), 64'd1);
    tick(1'b1, 1'b0);
    chk("R4 unchanged in Update-IR", 64'(bnd_drive), 64'd1);
    tick(1'b0, 1'b0);
    chk("R4 applied after Update-IR", 64'(bnd_drive), 64'd0);

    // R3: five high TMS edges from each state
    for (int s = 0; s < 16; s++) begin
      load_ir(3'b111, cap);
      for (int k = 0; k < path_len(s); k++) tick(path_bits(s)[k], 1'b0);
      chk("R10 oe only in shift states", 64'(tdo_oe), 64'(s == 3 || s == 10));
      for (int k = 0; k < 5; k++) tick(1'b1, 1'b0);
      chk("R3 oe low in Test-Logic-Reset", 64'(tdo_oe), 64'd0);
      tick(1'b0, 1'b0);
      scan_dr(32, 64'd0, d);
      chk("R3 ID path after five-high reset", d, 64'(IDV));
    end

    // R1: asynchronous reset in mid-operation
    load_ir(3'b111, cap);
    @(negedge tck); #0.5; trst_n = 1'b0; #1;
    chk("R1 async reset oe", 64'(tdo_oe), 64'd0);
    chk("R1 async reset bnd_out", 64'(bnd_out), 64'd0);
    @(negedge tck); #0.5; trst_n = 1'b1;
    tick(1'b0, 1'b0);
    scan_dr(32, 64'd0, d);
    chk("R1 ID path after async reset", d, 64'(IDV));

    summary();
    $finish;
  end
endmodule